// File: doc/BRIEF.md
# TLB Entry Maintenance Port

This block gives software a register window onto a small set-associative translation buffer. Software points a select register at one set and one index. It stages the upper word of an entry through a high-half register, which also copies the value into a cause register that software cannot write directly. A write to the low-half register then commits the whole entry. The committed entry takes the low word from that write and the high word from the cause register. Reads move the selected entry into the high-half and low-half mirror registers, so that software can inspect it.

A two-bit bank selector chooses which of two independent entry banks the port reaches. Only two of its four codes reach a bank. With the other two codes the registers behave as plain storage and the entries are neither written nor read. When a commit replaces an entry whose valid bit was set, the block pulses a flush request that carries the old virtual page address. A separate PID command compares the low byte of a new process identifier with the current one and requests a flush of the current PID's entries when they differ.

Top module: `tlb_entry_port`

## Requirements
- R1: Register address encoding is 0 = select, 1 = high half, 2 = low half, 3 = cause. The select register keeps data bits [5:0] and reads back zero-extended. Bits [3:0] pick one of 16 indices and bits [5:4] pick one of 4 sets, so every index and set combination names a distinct entry in each bank.
- R2: A bank_sel of 1 reaches bank 0 and a bank_sel of 2 reaches bank 1, and the two banks are independent. With bank_sel 0 or 3, no entry is committed, the mirrors are not loaded, a high-half write leaves the cause register alone and no flush is requested.
- R3: In bank mode a high-half write also writes the same data into the cause register. A write to address 3 is ignored, and the cause register reads back at address 3.
- R4: In bank mode a low-half write commits the selected entry: its low word is the written data and its high word is the cause register value from before that edge.
- R5: When a commit replaces an entry whose old low word has bit 3 set, flush_req is high for exactly the one cycle after the commit edge. In that cycle flush_vaddr equals the old high word with bits [12:0] cleared. A commit over an invalid entry gives no pulse.
- R6: In bank mode any read loads the high-half and low-half mirrors from the selected entry. rd_data is registered and presents the addressed register's new value one cycle after the request.
- R7: When pid_cmd is high, pid_flush_req pulses on the next cycle only if pid_new[7:0] differs from pid_cur[7:0]. In that cycle pid_flush_id carries the pid_cur value that was sampled.
- R8: Synchronous reset clears all registers and outputs and marks every entry invalid, so an entry read returns zero and the first commit after reset requests no flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bank_sel | input | 2 | Bank selector: 1 gives bank 0, 2 gives bank 1, other codes give no bank |
| req_valid | input | 1 | Register access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_reg | input | 2 | Register address |
| req_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| flush_req | output | 1 | One-cycle page flush request |
| flush_vaddr | output | 32 | Page address to flush |
| pid_cmd | input | 1 | PID flush command |
| pid_new | input | 32 | New process identifier |
| pid_cur | input | 32 | Current process identifier |
| pid_flush_req | output | 1 | One-cycle PID flush request |
| pid_flush_id | output | 32 | PID whose entries are to be flushed |

## Verification
The page flush from a commit and the PID flush command drive separate registered outputs, and both can fire on the same edge. The bench provokes this by committing over a valid entry in the same cycle as a PID command whose low byte differs from the current PID. It then expects both pulses in the following cycle: flush_vaddr holds the replaced entry's page and pid_flush_id holds the sampled current PID. A mix-up between the two paths shows up as a wrong value or a missing pulse on one of the two outputs.

// File: rtl/tlbp_pkg.sv
package tlbp_pkg;
  typedef enum logic [1:0] {
    REG_SEL   = 2'd0,
    REG_HI    = 2'd1,
    REG_LO    = 2'd2,
    REG_CAUSE = 2'd3
  } reg_id_e;

  localparam int NUM_BANKS = 2;

  function automatic logic bank_reachable(input logic [1:0] code);
    return (code == 2'd1) || (code == 2'd2);
  endfunction
endpackage

// File: rtl/tlbp_entry_mem.sv
module tlbp_entry_mem #(
  parameter int BANKS     = 2,
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 32,
  parameter int VALID_BIT = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [$clog2(BANKS)-1:0] bank,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     we,
  input  logic [DATA_W-1:0]        wlo,
  input  logic [DATA_W-1:0]        whi,
  output logic [DATA_W-1:0]        rlo,
  output logic [DATA_W-1:0]        rhi,
  output logic                     rvalid
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int BANK_W = $clog2(BANKS);

  logic [DATA_W-1:0] lo_rd [BANKS];
  logic [DATA_W-1:0] hi_rd [BANKS];

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    logic [DATA_W-1:0] lo_m [DEPTH];
    logic [DATA_W-1:0] hi_m [DEPTH];
    logic [DEPTH-1:0]  filled;
    logic              hit;

    assign hit = we && (bank == BANK_W'(g));

    // storage without reset so it maps to RAM
    always_ff @(posedge clk) begin
      if (hit) begin
        lo_m[addr] <= wlo;
        hi_m[addr] <= whi;
      end
    end

    // per-entry written flag gives the all-invalid reset state
    always_ff @(posedge clk) begin
      if (rst) filled <= '0;
      else if (hit) filled[addr] <= 1'b1;
    end

    assign lo_rd[g] = filled[addr] ? lo_m[addr] : '0;
    assign hi_rd[g] = filled[addr] ? hi_m[addr] : '0;
  end

  assign rlo    = lo_rd[bank];
  assign rhi    = hi_rd[bank];
  assign rvalid = rlo[VALID_BIT];

  // R4: a committed entry reads back with the written words
  p_readback_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(we) && $stable(addr) && $stable(bank)) |->
      (rlo == $past(wlo) && rhi == $past(whi)));
endmodule

// File: rtl/tlbp_pid_cmp.sv
module tlbp_pid_cmp #(
  parameter int PID_W   = 32,
  parameter int CMP_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd,
  input  logic [PID_W-1:0] pid_new,
  input  logic [PID_W-1:0] pid_cur,
  output logic             req,
  output logic [PID_W-1:0] req_id
);
  logic differ;
  logic unused_new_hi;

  assign differ        = pid_new[CMP_W-1:0] != pid_cur[CMP_W-1:0];
  assign unused_new_hi = ^pid_new[PID_W-1:CMP_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      req    <= 1'b0;
      req_id <= '0;
    end else begin
      req <= cmd && differ;
      if (cmd) req_id <= pid_cur;
    end
  end

  // R7: matching low bytes never raise a request
  p_pid_match_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd && (pid_new[CMP_W-1:0] == pid_cur[CMP_W-1:0])) |=> !req);

  // R7: request carries the sampled current PID
  p_pid_id_r7: assert property (@(posedge clk) disable iff (rst)
    req |-> (req_id == $past(pid_cur)));
endmodule

// File: rtl/tlb_entry_port.sv
module tlb_entry_port
  import tlbp_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int SET_W      = 2,
  parameter int IDX_W      = 4,
  parameter int PAGE_SHIFT = 13,
  parameter int VALID_BIT  = 3,
  parameter int PID_W      = 32,
  parameter int PID_CMP_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        bank_sel,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_reg,
  input  logic [DATA_W-1:0] req_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              flush_req,
  output logic [DATA_W-1:0] flush_vaddr,
  input  logic              pid_cmd,
  input  logic [PID_W-1:0]  pid_new,
  input  logic [PID_W-1:0]  pid_cur,
  output logic              pid_flush_req,
  output logic [PID_W-1:0]  pid_flush_id
);
  localparam int SEL_W = SET_W + IDX_W;
  localparam logic [DATA_W-1:0] PAGE_MASK = ~((DATA_W'(1) << PAGE_SHIFT) - DATA_W'(1));

  logic [SEL_W-1:0]  sel_q;
  logic [DATA_W-1:0] hi_q, lo_q, cause_q;
  logic              bank_en, bank_idx;
  logic              wr_go, rd_go, commit;
  reg_id_e           rid;
  logic [DATA_W-1:0] ent_lo, ent_hi;
  logic              ent_valid;

  assign bank_en  = bank_reachable(bank_sel);
  assign bank_idx = bank_sel[1];
  assign rid      = reg_id_e'(req_reg);
  assign wr_go    = req_valid && req_write;
  assign rd_go    = req_valid && !req_write;
  assign commit   = wr_go && (rid == REG_LO) && bank_en;

  tlbp_entry_mem #(
    .BANKS(NUM_BANKS), .ADDR_W(SEL_W), .DATA_W(DATA_W), .VALID_BIT(VALID_BIT)
  ) u_mem (
    .clk(clk), .rst(rst), .bank(bank_idx), .addr(sel_q), .we(commit),
    .wlo(req_data), .whi(cause_q),
    .rlo(ent_lo), .rhi(ent_hi), .rvalid(ent_valid)
  );

  tlbp_pid_cmp #(.PID_W(PID_W), .CMP_W(PID_CMP_W)) u_pid (
    .clk(clk), .rst(rst), .cmd(pid_cmd), .pid_new(pid_new), .pid_cur(pid_cur),
    .req(pid_flush_req), .req_id(pid_flush_id)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q       <= '0;
      hi_q        <= '0;
      lo_q        <= '0;
      cause_q     <= '0;
      rd_data     <= '0;
      flush_req   <= 1'b0;
      flush_vaddr <= '0;
    end else begin
      flush_req <= commit && ent_valid;
      if (commit && ent_valid) flush_vaddr <= ent_hi & PAGE_MASK;

      if (wr_go) begin
        unique case (rid)
          REG_SEL:   sel_q <= req_data[SEL_W-1:0];
          REG_HI: begin
            hi_q <= req_data;
            if (bank_en) cause_q <= req_data;
          end
          REG_LO:    lo_q <= req_data;
          REG_CAUSE: ;
        endcase
      end

      if (rd_go) begin
        if (bank_en) begin
          hi_q <= ent_hi;
          lo_q <= ent_lo;
        end
        unique case (rid)
          REG_SEL:   rd_data <= DATA_W'(sel_q);
          REG_HI:    rd_data <= bank_en ? ent_hi : hi_q;
          REG_LO:    rd_data <= bank_en ? ent_lo : lo_q;
          REG_CAUSE: rd_data <= cause_q;
        endcase
      end
    end
  end

  // R3: high-half write in bank mode lands in the cause register
  p_cause_copy_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_go && rid == REG_HI && bank_en) |=> (cause_q == $past(req_data)));

  // R3: cause register is not writable at its own address
  p_cause_ro_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_go && rid == REG_CAUSE) |=> $stable(cause_q));

  // R5: a flush pulse always follows a commit
  p_flush_src_r5: assert property (@(posedge clk) disable iff (rst)
    flush_req |-> $past(commit));

  // R5: flush address is page aligned
  p_flush_align_r5: assert property (@(posedge clk) disable iff (rst)
    flush_req |-> (flush_vaddr[PAGE_SHIFT-1:0] == '0));

  // R2: unreachable bank codes leave mirrors and flush untouched
  p_idle_mirror_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_go && !bank_en) |=> (hi_q == $past(hi_q) && lo_q == $past(lo_q)));

  p_idle_flush_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !bank_en) |=> !flush_req);
endmodule

// File: tb/tlb_entry_port_tb.sv
`timescale 1ns/1ps
module tlb_entry_port_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  bank_sel;
  logic        req_valid, req_write;
  logic [1:0]  req_reg;
  logic [31:0] req_data;
  logic [31:0] rd_data;
  logic        flush_req;
  logic [31:0] flush_vaddr;
  logic        pid_cmd;
  logic [31:0] pid_new, pid_cur;
  logic        pid_flush_req;
  logic [31:0] pid_flush_id;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tlb_entry_port u_dut (
    .clk(clk), .rst(rst), .bank_sel(bank_sel), .req_valid(req_valid),
    .req_write(req_write), .req_reg(req_reg), .req_data(req_data),
    .rd_data(rd_data), .flush_req(flush_req), .flush_vaddr(flush_vaddr),
    .pid_cmd(pid_cmd), .pid_new(pid_new), .pid_cur(pid_cur),
    .pid_flush_req(pid_flush_req), .pid_flush_id(pid_flush_id)
  );

  typedef struct packed {
    logic [1:0]  bank;
    logic        wr;
    logic [1:0]  rg;
    logic [31:0] data;
    logic        chk_rd;
    logic [31:0] exp_rd;
    logic        exp_fl;
    logic [31:0] exp_va;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 28;
  // registers: 0 select, 1 high, 2 low, 3 cause
  localparam vec_t VECS [NV] = '{
    '{2'd1,1'b1,2'd0,32'hFFFFFF25,1'b0,32'h0,       1'b0,32'h0,       4'd1}, // R1
    '{2'd1,1'b0,2'd0,32'h0,       1'b1,32'h25,      1'b0,32'h0,       4'd1}, // R1
    '{2'd1,1'b1,2'd1,32'h12347FFF,1'b0,32'h0,       1'b0,32'h0,       4'd3}, // R3
    '{2'd1,1'b0,2'd3,32'h0,       1'b1,32'h12347FFF,1'b0,32'h0,       4'd3}, // R3
    '{2'd1,1'b1,2'd2,32'h00000008,1'b0,32'h0,       1'b0,32'h0,       4'd4}, // R4
    '{2'd1,1'b1,2'd1,32'h5555A123,1'b0,32'h0,       1'b0,32'h0,       4'd4}, // R4
    '{2'd1,1'b1,2'd2,32'h00000009,1'b0,32'h0,       1'b1,32'h12346000,4'd5}, // R5
    '{2'd1,1'b1,2'd1,32'h0,       1'b0,32'h0,       1'b0,32'h0,       4'd5}, // R5 pulse ends
    '{2'd1,1'b0,2'd1,32'h0,       1'b1,32'h5555A123,1'b0,32'h0,       4'd6}, // R6
    '{2'd1,1'b0,2'd2,32'h0,       1'b1,32'h00000009,1'b0,32'h0,       4'd6}, // R6
    '{2'd1,1'b1,2'd2,32'h0,       1'b0,32'h0,       1'b1,32'h5555A000,4'd5}, // R5
    '{2'd1,1'b1,2'd2,32'h0,       1'b0,32'h0,       1'b0,32'h0,       4'd5}, // R5 invalid old
    '{2'd2,1'b0,2'd2,32'h0,       1'b1,32'h0,       1'b0,32'h0,       4'd2}, // R2
    '{2'd0,1'b1,2'd1,32'h77777777,1'b0,32'h0,       1'b0,32'h0,       4'd2}, // R2
    '{2'd0,1'b1,2'd2,32'h00000008,1'b0,32'h0,       1'b0,32'h0,       4'd2}, // R2
    '{2'd1,1'b0,2'd3,32'h0,       1'b1,32'h0,       1'b0,32'h0,       4'd2}, // R2
    '{2'd1,1'b0,2'd2,32'h0,       1'b1,32'h0,       1'b0,32'h0,       4'd2}, // R2
    '{2'd1,1'b1,2'd3,32'hFFFFFFFF,1'b0,32'h0,       1'b0,32'h0,       4'd3}, // R3
    '{2'd1,1'b0,2'd3,32'h0,       1'b1,32'h0,       1'b0,32'h0,       4'd3}, // R3
    '{2'd0,1'b1,2'd1,32'h77777777,1'b0,32'h0,       1'b0,32'h0,       4'd2}, // R2
    '{2'd3,1'b0,2'd1,32'h0,       1'b1,32'h77777777,1'b0,32'h0,       4'd2}, // R2
    '{2'd2,1'b1,2'd0,32'h0000003F,1'b0,32'h0,       1'b0,32'h0,       4'd2}, // R2
    '{2'd2,1'b1,2'd1,32'h00002000,1'b0,32'h0,       1'b0,32'h0,       4'd2}, // R2
    '{2'd2,1'b1,2'd2,32'h00000008,1'b0,32'h0,       1'b0,32'h0,       4'd2}, // R2
    '{2'd1,1'b0,2'd2,32'h0,       1'b1,32'h0,       1'b0,32'h0,       4'd2}, // R2
    '{2'd2,1'b0,2'd1,32'h0,       1'b1,32'h00002000,1'b0,32'h0,       4'd6}, // R6
    '{2'd2,1'b1,2'd0,32'h0000002F,1'b0,32'h0,       1'b0,32'h0,       4'd1}, // R1
    '{2'd2,1'b0,2'd1,32'h0,       1'b1,32'h0,       1'b0,32'h0,       4'd1}  // R1
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] b, input logic v, input logic w,
                       input logic [1:0] r, input logic [31:0] d);
    @(negedge clk);
    bank_sel = b; req_valid = v; req_write = w; req_reg = r; req_data = d;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; bank_sel = 2'd0; req_valid = 1'b0; req_write = 1'b0;
    req_reg = 2'd0; req_data = '0; pid_cmd = 1'b0; pid_new = '0; pid_cur = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R8: reset state at the outputs
    #1;
    check("R8 rd_data", rd_data, 32'h0);
    check("R8 flush_req", {31'b0, flush_req}, 32'h0);
    check("R8 pid_flush_req", {31'b0, pid_flush_req}, 32'h0);
    drive(2'd1, 1'b1, 1'b0, 2'd2, 32'h0);
    check("R8 entry lo after reset", rd_data, 32'h0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].bank, 1'b1, VECS[i].wr, VECS[i].rg, VECS[i].data);
      check($sformatf("R%0d vec %0d flush_req", VECS[i].req, i),
            {31'b0, flush_req}, {31'b0, VECS[i].exp_fl});
      if (VECS[i].exp_fl)
        check($sformatf("R%0d vec %0d flush_vaddr", VECS[i].req, i),
              flush_vaddr, VECS[i].exp_va);
      if (VECS[i].chk_rd)
        check($sformatf("R%0d vec %0d rd_data", VECS[i].req, i),
              rd_data, VECS[i].exp_rd);
    end

    // R7: equal low bytes, upper bits differ -> no request
    @(negedge clk);
    req_valid = 1'b0; pid_cmd = 1'b1; pid_new = 32'h000001AB; pid_cur = 32'h000002AB;
    @(posedge clk); #1;
    check("R7 equal low byte", {31'b0, pid_flush_req}, 32'h0);
    @(negedge clk);
    pid_new = 32'h000001AC;
    @(posedge clk); #1;
    check("R7 differ req", {31'b0, pid_flush_req}, 32'h1);
    check("R7 differ id", pid_flush_id, 32'h000002AB);
    @(negedge clk);
    pid_cmd = 1'b0;
    @(posedge clk); #1;
    check("R7 pulse ends", {31'b0, pid_flush_req}, 32'h0);

    // R5 with R7 on the same edge: bank 1 entry 0x3F is valid with high 0x2000
    drive(2'd2, 1'b1, 1'b1, 2'd0, 32'h0000003F);
    @(negedge clk);
    bank_sel = 2'd2; req_valid = 1'b1; req_write = 1'b1; req_reg = 2'd2; req_data = 32'h8;
    pid_cmd = 1'b1; pid_new = 32'h11; pid_cur = 32'h22;
    @(posedge clk); #1;
    check("R5 coincident flush_req", {31'b0, flush_req}, 32'h1);
    check("R5 coincident flush_vaddr", flush_vaddr, 32'h00002000);
    check("R7 coincident pid req", {31'b0, pid_flush_req}, 32'h1);
    check("R7 coincident pid id", pid_flush_id, 32'h22);
    @(negedge clk);
    pid_cmd = 1'b0; req_valid = 1'b0;

    // R8: reset invalidates every entry
    @(negedge clk) rst = 1'b1;
    @(posedge clk);
    @(negedge clk) rst = 1'b0;
    drive(2'd2, 1'b1, 1'b1, 2'd0, 32'h0000003F);
    drive(2'd2, 1'b1, 1'b1, 2'd2, 32'h00000008);
    check("R8 no flush after reset", {31'b0, flush_req}, 32'h0);
    drive(2'd2, 1'b1, 1'b0, 2'd1, 32'h0);
    check("R8 cause cleared into entry", rd_data, 32'h0);

    @(negedge clk) req_valid = 1'b0;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule